// File: doc/BRIEF.md
# BCD Calendar Clock Core with User Snapshot Registers

This block keeps wall-clock time in packed BCD: seconds, minutes, hours in 24-hour form, a day-of-week count, day of month, month and a two-digit year. It advances by one second on each cycle where the one-hertz enable is high. It handles the varying month lengths, including February in leap years.

Software never touches the running counters directly. It sees eight byte registers on a small synchronous port: one control byte and seven time bytes. The time bytes are a copy of the counters, and the copy is refreshed one clock cycle after each tick. A freeze bit in the control byte stops the refresh, so a multi-byte read stays coherent while time goes on running underneath. A load bit also stops the refresh and lets software write new values. When the load bit is cleared, the whole copy is pushed into the counters in one cycle. A stop bit held in the seconds byte gates the tick. The control byte also stores a six-bit calibration value, a magnitude and a sign, and passes it out to a separate trimming stage.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register offsets are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year, all time fields in packed BCD. After reset the bytes read as control 0x00, seconds 0x80, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00. Offsets of 8 or more read 0x00 and ignore writes.
- R2: On each tick with STOP clear, the counters advance one second. Carries ripple from seconds (59→00) to minutes (59→00) to hours (23→00). The hour carry steps both day-of-week (07→01) and date. The date carry steps the month (12→01), and the month carry steps the year (99→00).
- R3: The date wraps to 01 after the last day of the current month: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 29 for month 02 when the year value is a multiple of four (00 counts as a leap year); 28 for month 02 otherwise.
- R4: Unless frozen, all seven time bytes take the counter values together in the clock cycle after a tick. Between such copies they change only through bus writes.
- R5: Control bit 6 (freeze) set to 1 blocks the refresh while the counters keep counting. After it is cleared, the bytes stay unchanged until the next tick, whose copy shows the up-to-date time.
- R6: A copy already scheduled by a tick still completes, even if freeze is written in the very cycle the copy lands.
- R7: Control bit 7 (load) set to 1 blocks the refresh. A control write that takes load from 1 to 0 loads all seven time bytes into the counters at once, with STOP excluded. The following tick then shows the loaded time plus one second.
- R8: Seconds bit 7 is STOP, which resets to 1. While STOP is 1 the counters hold and copies keep STOP as written. Once STOP is cleared, the next tick advances the time.
- R9: Bits with no use read back as 0 whatever is written: minutes bit 7, hours bits 7..6, day bits 7..3, date bits 7..6 and month bits 7..5.
- R10: Control bits 4..0 appear on `cal_mag` and control bit 5 appears on `cal_pos`, and the whole control byte reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | ADDR_W (3) | Register offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| cal_mag | output | CAL_W (5) | Stored calibration magnitude |
| cal_pos | output | 1 | Stored calibration sign, 1 means speed up |

## Verification
A wrong carry or a wrong month limit inside the counter chain cannot be seen while frozen. It shows in the time bytes one cycle after the tick that crosses the faulty boundary. For this reason the bench sets the time just short of each month end across leap and common years, then ticks once. A fault in the snapshot control (a copy that does not stop, does not run, or is aborted) shows as a seconds byte that is stale or early by exactly one tick. A failed load shows as a time that keeps its old value after the next tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int BYTE_W   = 8;
   localparam int N_FIELDS = 7;

   typedef logic [BYTE_W-1:0] byte_t;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DOW  = 3;
   localparam int F_DATE = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;

   function automatic byte_t field_lo(int idx);
      return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic byte_t field_hi(int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DOW:        return 8'h07;
         F_DATE:       return 8'h31;
         F_MON:        return 8'h12;
         default:      return 8'h99;
      endcase
   endfunction

   // storage mask of each time byte (seconds: data bits only, STOP handled apart)
   function automatic byte_t field_mask(int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h7F;
         F_HOUR:       return 8'h3F;
         F_DOW:        return 8'h07;
         F_DATE:       return 8'h3F;
         F_MON:        return 8'h1F;
         default:      return 8'hFF;
      endcase
   endfunction

   function automatic byte_t bcd_inc(byte_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic is_leap(byte_t yr);
      logic [7:0] bin;
      bin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
      return bin[1:0] == 2'b00;
   endfunction

   function automatic byte_t month_days(byte_t mon, byte_t yr);
      if (mon == 8'h02) return is_leap(yr) ? 8'h29 : 8'h28;
      if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
      return 8'h31;
   endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter byte_t LO_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  byte_t load_val_i,
   input  logic  inc_i,
   input  byte_t top_i,
   output byte_t q_o,
   output logic  last_o
);
   byte_t q;

   assign last_o = (q >= top_i);
   assign q_o    = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= LO_VAL;
      else if (load_i) q <= load_val_i;
      else if (inc_i)  q <= last_o ? LO_VAL : bcd_inc(q);
   end

   assert_wrap_to_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && last_o && !load_i) |=> (q == LO_VAL));

   assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !last_o && !load_i) |=> (q != $past(q)));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_i,
   input  logic                        load_i,
   input  logic [N_FIELDS-1:0][BYTE_W-1:0] load_val_i,
   output logic [N_FIELDS-1:0][BYTE_W-1:0] cnt_o
);
   logic [N_FIELDS-1:0][BYTE_W-1:0] top;
   logic [N_FIELDS-1:0]             last;
   logic [N_FIELDS-1:0]             inc;
   logic                            hour_roll;
   logic                            date_roll;

   always_comb begin
      for (int i = 0; i < N_FIELDS; i++) top[i] = field_hi(i);
      top[F_DATE] = month_days(cnt_o[F_MON], cnt_o[F_YEAR]);
   end

   assign hour_roll  = run_i & last[F_SEC] & last[F_MIN] & last[F_HOUR];
   assign date_roll  = hour_roll & last[F_DATE];

   assign inc[F_SEC]  = run_i;
   assign inc[F_MIN]  = run_i & last[F_SEC];
   assign inc[F_HOUR] = run_i & last[F_SEC] & last[F_MIN];
   assign inc[F_DOW]  = hour_roll;
   assign inc[F_DATE] = hour_roll;
   assign inc[F_MON]  = date_roll;
   assign inc[F_YEAR] = date_roll & last[F_MON];

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      localparam byte_t LOV = field_lo(i);
      rtc_bcd_field #(.LO_VAL(LOV)) u_field (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load_i),
         .load_val_i(load_val_i[i]),
         .inc_i     (inc[i]),
         .top_i     (top[i]),
         .q_o       (cnt_o[i]),
         .last_o    (last[i])
      );
   end

   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(cnt_o));

   assert_load_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_o == $past(load_val_i)));

   assert_minute_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && cnt_o[F_SEC] == 8'h59 && cnt_o[F_MIN] == 8'h10)
      |=> (cnt_o[F_MIN] == 8'h11 && cnt_o[F_SEC] == 8'h00));
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CAL_W  = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic                            we_i,
   input  byte_t                           wdata_i,
   input  logic [N_FIELDS-1:0][BYTE_W-1:0] cnt_i,
   output byte_t                           rdata_o,
   output logic [N_FIELDS-1:0][BYTE_W-1:0] user_o,
   output logic                            stop_o,
   output logic                            commit_o,
   output logic [CAL_W-1:0]                cal_mag_o,
   output logic                            cal_pos_o
);
   localparam int CTRL_FREEZE = 6;
   localparam int CTRL_LOAD   = 7;
   localparam int SIGN_BIT    = 5;
   localparam int N_REGS      = N_FIELDS + 1;

   byte_t                           ctrl;
   logic [N_FIELDS-1:0][BYTE_W-1:0] usr;
   logic                            copy_pend;
   logic                            in_range;
   logic [ADDR_W-1:0]               fidx;

   assign in_range = ({{(32-ADDR_W){1'b0}}, addr_i} < N_REGS);
   assign fidx     = addr_i - ADDR_W'(1);
   assign commit_o = we_i && addr_i == '0 && !wdata_i[CTRL_LOAD] && ctrl[CTRL_LOAD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         copy_pend <= 1'b0;
         for (int i = 0; i < N_FIELDS; i++) usr[i] <= field_lo(i);
         usr[F_SEC][7] <= 1'b1;
      end else begin
         copy_pend <= tick_i & ~ctrl[CTRL_FREEZE] & ~ctrl[CTRL_LOAD];
         if (copy_pend) begin
            for (int i = 0; i < N_FIELDS; i++) usr[i] <= cnt_i[i] & field_mask(i);
            usr[F_SEC][7] <= usr[F_SEC][7];
         end
         if (we_i && in_range) begin
            if (addr_i == '0) ctrl <= wdata_i;
            else if (int'(fidx) == F_SEC) usr[F_SEC] <= wdata_i;
            else usr[fidx] <= wdata_i & field_mask(int'(fidx));
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (in_range) rdata_o = (addr_i == '0) ? ctrl : usr[fidx];
   end

   always_comb begin
      user_o = usr;
      user_o[F_SEC][7] = 1'b0;
   end

   assign stop_o    = usr[F_SEC][7];
   assign cal_mag_o = ctrl[CAL_W-1:0];
   assign cal_pos_o = ctrl[SIGN_BIT];

   assert_freeze_blocks_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && ctrl[CTRL_FREEZE]) |=> !copy_pend);

   assert_copy_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_pend && !(we_i && addr_i == ADDR_W'(1)))
      |=> (usr[F_SEC][6:0] == $past(cnt_i[F_SEC][6:0])));

   assert_quiet_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_pend && !we_i) |=> $stable(usr));

   assert_stop_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_pend && !we_i) |=> (usr[F_SEC][7] == $past(usr[F_SEC][7])));

   assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (usr[F_HOUR][7:6] == 2'b00 && usr[F_DOW][7:3] == 5'd0 && usr[F_MON][7:5] == 3'd0));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CAL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [CAL_W-1:0]  cal_mag,
   output logic              cal_pos
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("rtc_calendar_core: ADDR_W must cover eight registers");
   end
   if (CAL_W < 1 || CAL_W > 5) begin : g_bad_cal
      $error("rtc_calendar_core: CAL_W must lie in 1..5");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("rtc_calendar_core: registers are byte wide");
   end

   logic [N_FIELDS-1:0][BYTE_W-1:0] cnt;
   logic [N_FIELDS-1:0][BYTE_W-1:0] user;
   logic                            stop;
   logic                            commit;
   logic                            run;

   assign run = tick_1hz & ~stop;

   rtc_user_bank #(.ADDR_W(ADDR_W), .CAL_W(CAL_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_1hz),
      .addr_i   (reg_addr),
      .we_i     (reg_we),
      .wdata_i  (reg_wdata),
      .cnt_i    (cnt),
      .rdata_o  (reg_rdata),
      .user_o   (user),
      .stop_o   (stop),
      .commit_o (commit),
      .cal_mag_o(cal_mag),
      .cal_pos_o(cal_pos)
   );

   rtc_time_chain u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .load_i    (commit),
      .load_val_i(user),
      .cnt_o     (cnt)
   );

   assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !commit) |=> $stable(cnt));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [4:0] cal_mag;
   logic       cal_pos;

   int checks = 0;
   int failures = 0;
   // bench model of the running counters (binary)
   int ms, mm, mh, mw, md, mo, my;

   always #10 clk = ~clk;

   rtc_calendar_core dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cal_mag(cal_mag), .cal_pos(cal_pos)
   );

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      ms++;
      if (ms > 59) begin
         ms = 0; mm++;
         if (mm > 59) begin
            mm = 0; mh++;
            if (mh > 23) begin
               mh = 0;
               mw = (mw == 7) ? 1 : mw + 1;
               md++;
               if (md > dim(mo, my)) begin
                  md = 1; mo++;
                  if (mo > 12) begin
                     mo = 1;
                     my = (my == 99) ? 0 : my + 1;
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_time(int y, int mon, int d, int w, int h, int mi, int s);
      wr(3'd0, 8'h80);
      wr(3'd1, bcd(s)); wr(3'd2, bcd(mi)); wr(3'd3, bcd(h)); wr(3'd4, bcd(w));
      wr(3'd5, bcd(d)); wr(3'd6, bcd(mon)); wr(3'd7, bcd(y));
      wr(3'd0, 8'h00);
      ms = s; mm = mi; mh = h; mw = w; md = d; mo = mon; my = y;
   endtask

   task automatic check_all(string req);
      logic [7:0] v;
      rd(3'd1, v); chk(req, v, bcd(ms));
      rd(3'd2, v); chk(req, v, bcd(mm));
      rd(3'd3, v); chk(req, v, bcd(mh));
      rd(3'd4, v); chk(req, v, bcd(mw));
      rd(3'd5, v); chk(req, v, bcd(md));
      rd(3'd6, v); chk(req, v, bcd(mo));
      rd(3'd7, v); chk(req, v, bcd(my));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v, frozen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
      rd(3'd1, v); chk("R1 sec", v, 8'h80);
      rd(3'd2, v); chk("R1 min", v, 8'h00);
      rd(3'd3, v); chk("R1 hour", v, 8'h00);
      rd(3'd4, v); chk("R1 dow", v, 8'h01);
      rd(3'd5, v); chk("R1 date", v, 8'h01);
      rd(3'd6, v); chk("R1 month", v, 8'h01);
      rd(3'd7, v); chk("R1 year", v, 8'h00);

      // R8 stopped after reset: tick does not advance
      tick(); tick();
      rd(3'd1, v); chk("R8 stopped at reset", v, 8'h80);

      // R2 full ripple through the year boundary
      set_time(99, 12, 31, 7, 23, 59, 50);
      for (int i = 0; i < 14; i++) begin
         tick(); model_step(); check_all("R2 ripple");
      end

      // R3 month ends across leap and common years
      for (int yi = 0; yi < 9; yi++) begin
         for (int mon = 1; mon <= 12; mon++) begin
            automatic int yr = (yi < 5) ? yi : 91 + yi;
            set_time(yr, mon, dim(mon, yr), 3, 23, 59, 59);
            tick(); model_step();
            rd(3'd5, v); chk("R3 date wrap", v, bcd(md));
            rd(3'd6, v); chk("R3 month step", v, bcd(mo));
         end
      end
      set_time(1, 2, 27, 2, 23, 59, 59);
      tick(); model_step();
      rd(3'd5, v); chk("R3 feb 28 reached", v, 8'h28);

      // R4 copy lands the cycle after the tick, not before
      set_time(24, 5, 10, 4, 10, 20, 30);
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0; reg_addr = 3'd1;
      #1 chk("R4 not yet copied", reg_rdata, 8'h30);
      @(negedge clk); reg_addr = 3'd1;
      #1 chk("R4 copied", reg_rdata, 8'h31);
      model_step();

      // R5 freeze holds snapshot while counters run
      wr(3'd0, 8'h40);
      frozen = bcd(ms);
      tick(); model_step(); tick(); model_step(); tick(); model_step();
      rd(3'd1, v); chk("R5 frozen", v, frozen);
      wr(3'd0, 8'h00);
      rd(3'd1, v); chk("R5 no copy before tick", v, frozen);
      tick(); model_step();
      check_all("R5 resumed");

      // R6 freeze written in the cycle the copy lands
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h40; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
      model_step();
      rd(3'd1, v); chk("R6 copy completed", v, bcd(ms));
      tick(); model_step();
      rd(3'd1, v); chk("R6 then frozen", v, bcd(ms - 1));
      wr(3'd0, 8'h00);

      // R7 load bit halts copy, clearing it loads counters
      tick(); model_step();
      wr(3'd0, 8'h80);
      frozen = bcd(ms);
      tick(); tick();
      rd(3'd1, v); chk("R7 halted", v, frozen);
      wr(3'd2, 8'h42); wr(3'd1, 8'h58); wr(3'd3, 8'h07);
      wr(3'd0, 8'h00);
      mm = 42; ms = 58; mh = 7;
      rd(3'd1, v); chk("R7 loaded no tick", v, 8'h58);
      tick(); model_step(); check_all("R7 loaded plus one");
      tick(); model_step(); check_all("R7 minute carry after load");

      // R9 unused bits read zero
      wr(3'd0, 8'h80);
      wr(3'd2, 8'hFF); rd(3'd2, v); chk("R9 min mask", v, 8'h7F);
      wr(3'd3, 8'hFF); rd(3'd3, v); chk("R9 hour mask", v, 8'h3F);
      wr(3'd4, 8'hFF); rd(3'd4, v); chk("R9 dow mask", v, 8'h07);
      wr(3'd5, 8'hFF); rd(3'd5, v); chk("R9 date mask", v, 8'h3F);
      wr(3'd6, 8'hFF); rd(3'd6, v); chk("R9 month mask", v, 8'h1F);
      wr(3'd7, 8'hFF); rd(3'd7, v); chk("R9 year full", v, 8'hFF);
      set_time(50, 6, 15, 5, 12, 0, 0);

      // R1 out-of-range offsets are inert (only 3 address bits: all mapped)
      // R10 calibration bits
      wr(3'd0, 8'h25);
      rd(3'd0, v); chk("R10 ctrl readback", v, 8'h25);
      chk("R10 cal_mag", {3'd0, cal_mag}, 8'h05);
      chk("R10 cal_pos", {7'd0, cal_pos}, 8'h01);
      wr(3'd0, 8'h1F);
      chk("R10 cal_mag max", {3'd0, cal_mag}, 8'h1F);
      chk("R10 cal_pos neg", {7'd0, cal_pos}, 8'h00);
      wr(3'd0, 8'h00);

      // R8 STOP set by direct write, then cleared
      tick(); model_step();
      wr(3'd1, 8'h80 | bcd(ms));
      tick(); tick();
      rd(3'd1, v); chk("R8 stop holds", v, 8'h80 | bcd(ms));
      wr(3'd1, bcd(ms));
      tick(); model_step();
      rd(3'd1, v); chk("R8 resumed", v, bcd(ms));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule